// File: doc/BRIEF.md
# System Identification Register Slave

An AXI4-Lite slave that tells software which hardware build it is running on. A handful of word registers sit at the bottom of its 64 KiB byte space: a fixed version word, an identifier set at elaboration time, a scratch word software can write and read back to prove the path works, and a constant ASCII signature. Two windows further up are forwarded to external ROMs. One ROM holds build information for the whole design. The other holds build information for a partial-reconfiguration region.

For a read that lands in a window, the slave drives the word offset inside that window onto a shared ROM address output. It waits for the synchronous ROMs, which have one clock of latency, and returns the data of the ROM that belongs to the window. Every other location, including every window word, ignores writes, but the write handshake still completes. All reads take the same number of cycles, whether they hit a register, a window or nothing.

Top module: `sysid_regs_axil`

## Requirements
- R1: After reset (synchronous, active-high `rst`), RVALID and BVALID are 0, AWREADY and WREADY are 0, ARREADY is 1, and the scratch word reads as 0x00000000.
- R2: A read of byte address 0x0000 returns 0x00010061 (major 0x0001 in bits 31:16, minor 0x00 in bits 15:8, patch 0x61 in bits 7:0).
- R3: A read of byte address 0x0004 returns the value of the ID_VALUE parameter.
- R4: Byte address 0x0008 is a read-write scratch word. A write updates byte lane k (bits 8k+7:8k) only when WSTRB[k] is 1, and a read returns the current value.
- R5: A read of byte address 0x000C returns 0x53594944 (ASCII "SYID").
- R6: A read of word address 0x200 to 0x3FF (byte 0x0800 to 0x0FFC) drives the word address bits [8:0] on `rom_word_addr` from the cycle after the AR handshake, and returns `sys_rom_q`.
- R7: A read of word address 0x400 to 0x5FF (byte 0x1000 to 0x17FC) drives the word address bits [8:0] on `rom_word_addr` from the cycle after the AR handshake, and returns `prr_rom_q`.
- R8: A read of any other word (0x004 to 0x1FF, or 0x600 and up) returns 0.
- R9: A write to any address other than 0x0008 changes nothing that can be read back, and it still completes with BVALID and response OKAY.
- R10: Only one read is in flight at a time. ARREADY is 0 from the accepting edge until the R handshake. RVALID rises at the second rising edge after the edge that accepts AR. RDATA holds steady while RVALID is 1 and RREADY is 0.
- R11: AWREADY and WREADY rise together, one edge after AWVALID and WVALID are both seen, and never while only one of them is valid. BVALID rises at the handshake edge and holds until BREADY. BRESP and RRESP are always 2'b00, and the prot inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| axil_awaddr | input | 16 | Write byte address |
| axil_awprot | input | 3 | Write protection (ignored) |
| axil_awvalid | input | 1 | Write address valid |
| axil_awready | output | 1 | Write address ready |
| axil_wdata | input | 32 | Write data |
| axil_wstrb | input | 4 | Write byte enables |
| axil_wvalid | input | 1 | Write data valid |
| axil_wready | output | 1 | Write data ready |
| axil_bresp | output | 2 | Write response (always OKAY) |
| axil_bvalid | output | 1 | Write response valid |
| axil_bready | input | 1 | Write response ready |
| axil_araddr | input | 16 | Read byte address |
| axil_arprot | input | 3 | Read protection (ignored) |
| axil_arvalid | input | 1 | Read address valid |
| axil_arready | output | 1 | Read address ready |
| axil_rdata | output | 32 | Read data |
| axil_rresp | output | 2 | Read response (always OKAY) |
| axil_rvalid | output | 1 | Read data valid |
| axil_rready | input | 1 | Read data ready |
| sys_rom_q | input | 32 | Data from the full-design build ROM |
| prr_rom_q | input | 32 | Data from the reconfigurable-region build ROM |
| rom_word_addr | output | 9 | Shared word address to both ROMs |

## Verification
Read results are due at the second rising edge after the AR handshake. The bench therefore samples at the falling edges after the handshake edge and after the next edge, expecting RVALID low at both and `rom_word_addr` already valid at the first, and expects the data at the third falling edge. AWREADY and WREADY are due one edge after both valids, and BVALID at the edge after that. Each of these is sampled at the falling edge that follows. The bench models the ROMs as synchronous memories whose contents are functions of their address, so the expected window data is computed from the address alone. While RREADY or BREADY is held back for a random number of cycles, the bench checks on every falling edge that the response stays put.

// File: rtl/sysid_pkg.sv
package sysid_pkg;
  localparam logic [31:0] VERSION_WORD   = 32'h0001_0061;
  localparam logic [31:0] SIGNATURE_WORD = 32'h5359_4944;

  typedef enum logic [2:0] {
    SEL_VER,
    SEL_ID,
    SEL_SCR,
    SEL_SIG,
    SEL_SYSROM,
    SEL_PRROM,
    SEL_NONE
  } sel_t;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_ISSUE,
    RD_FETCH,
    RD_RESP
  } rd_state_t;
endpackage

// File: rtl/sysid_addr_dec.sv
module sysid_addr_dec
  import sysid_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [ROM_AW-1:0] offs
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int WIN_W  = WORD_W - ROM_AW;

  logic [WORD_W-1:0] word;
  logic [WIN_W-1:0]  win;
  logic [1:0]        byte_unused;

  assign word        = addr[ADDR_W-1:2];
  assign win         = word[WORD_W-1:ROM_AW];
  assign offs        = word[ROM_AW-1:0];
  assign byte_unused = addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    if (win == WIN_W'(1)) begin
      sel = SEL_SYSROM;
    end else if (win == WIN_W'(2)) begin
      sel = SEL_PRROM;
    end else if (word < WORD_W'(4)) begin
      case (word[1:0])
        2'd0:    sel = SEL_VER;
        2'd1:    sel = SEL_ID;
        2'd2:    sel = SEL_SCR;
        default: sel = SEL_SIG;
      endcase
    end
  end
endmodule

// File: rtl/sysid_wr_path.sv
module sysid_wr_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic              bready,
  input  logic              hit_scratch,
  output logic              aw_w_ready,
  output logic              bvalid,
  output logic [DATA_W-1:0] scratch
);
  localparam int LANES = DATA_W / 8;

  logic fire;
  assign fire = aw_w_ready && awvalid && wvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_w_ready <= 1'b0;
      bvalid     <= 1'b0;
    end else begin
      aw_w_ready <= awvalid && wvalid && !aw_w_ready && !bvalid;
      if (fire) begin
        bvalid <= 1'b1;
      end else if (bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        scratch[b*8 +: 8] <= 8'h00;
      end else if (fire && hit_scratch && wstrb[b]) begin
        scratch[b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/sysid_rd_path.sv
module sysid_rd_path
  import sysid_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ROM_AW   = 9,
  parameter logic [31:0] ID_VALUE = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  input  sel_t              sel,
  input  logic [ROM_AW-1:0] offs,
  input  logic              rready,
  input  logic [DATA_W-1:0] scratch,
  input  logic [DATA_W-1:0] sys_q,
  input  logic [DATA_W-1:0] prr_q,
  output logic              arready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ROM_AW-1:0] rom_addr
);
  rd_state_t   state;
  sel_t        sel_q;
  logic [DATA_W-1:0] mux_d;

  assign arready = (state == RD_IDLE);

  always_comb begin
    case (sel_q)
      SEL_VER:    mux_d = DATA_W'(VERSION_WORD);
      SEL_ID:     mux_d = DATA_W'(ID_VALUE);
      SEL_SCR:    mux_d = scratch;
      SEL_SIG:    mux_d = DATA_W'(SIGNATURE_WORD);
      SEL_SYSROM: mux_d = sys_q;
      SEL_PRROM:  mux_d = prr_q;
      default:    mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RD_IDLE;
      sel_q    <= SEL_NONE;
      rvalid   <= 1'b0;
      rdata    <= '0;
      rom_addr <= '0;
    end else begin
      case (state)
        RD_IDLE: if (arvalid) begin
          sel_q    <= sel;
          rom_addr <= offs;
          state    <= RD_ISSUE;
        end
        RD_ISSUE: state <= RD_FETCH;
        RD_FETCH: begin
          rdata  <= mux_d;
          rvalid <= 1'b1;
          state  <= RD_RESP;
        end
        default: if (rready) begin
          rvalid <= 1'b0;
          state  <= RD_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sysid_regs_axil.sv
module sysid_regs_axil
  import sysid_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          ROM_AW   = 9,
  parameter logic [31:0] ID_VALUE = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   axil_awaddr,
  input  logic [2:0]          axil_awprot,
  input  logic                axil_awvalid,
  output logic                axil_awready,
  input  logic [DATA_W-1:0]   axil_wdata,
  input  logic [DATA_W/8-1:0] axil_wstrb,
  input  logic                axil_wvalid,
  output logic                axil_wready,
  output logic [1:0]          axil_bresp,
  output logic                axil_bvalid,
  input  logic                axil_bready,
  input  logic [ADDR_W-1:0]   axil_araddr,
  input  logic [2:0]          axil_arprot,
  input  logic                axil_arvalid,
  output logic                axil_arready,
  output logic [DATA_W-1:0]   axil_rdata,
  output logic [1:0]          axil_rresp,
  output logic                axil_rvalid,
  input  logic                axil_rready,
  input  logic [DATA_W-1:0]   sys_rom_q,
  input  logic [DATA_W-1:0]   prr_rom_q,
  output logic [ROM_AW-1:0]   rom_word_addr
);
  sel_t              rd_sel, wr_sel;
  logic [ROM_AW-1:0] rd_offs, wr_offs_unused;
  logic [DATA_W-1:0] scratch;
  logic              aw_w_ready;
  logic [5:0]        prot_unused;

  assign prot_unused  = {axil_awprot, axil_arprot};
  assign axil_awready = aw_w_ready;
  assign axil_wready  = aw_w_ready;
  assign axil_bresp   = 2'b00;
  assign axil_rresp   = 2'b00;

  sysid_addr_dec #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_rd_dec (
    .addr(axil_araddr), .sel(rd_sel), .offs(rd_offs)
  );

  sysid_addr_dec #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_wr_dec (
    .addr(axil_awaddr), .sel(wr_sel), .offs(wr_offs_unused)
  );

  sysid_wr_path #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awvalid(axil_awvalid), .wvalid(axil_wvalid),
    .wdata(axil_wdata), .wstrb(axil_wstrb), .bready(axil_bready),
    .hit_scratch(wr_sel == SEL_SCR),
    .aw_w_ready(aw_w_ready), .bvalid(axil_bvalid), .scratch(scratch)
  );

  sysid_rd_path #(.DATA_W(DATA_W), .ROM_AW(ROM_AW), .ID_VALUE(ID_VALUE)) u_rd (
    .clk(clk), .rst(rst),
    .arvalid(axil_arvalid), .sel(rd_sel), .offs(rd_offs),
    .rready(axil_rready), .scratch(scratch),
    .sys_q(sys_rom_q), .prr_q(prr_rom_q),
    .arready(axil_arready), .rvalid(axil_rvalid), .rdata(axil_rdata),
    .rom_addr(rom_word_addr)
  );
endmodule

// File: rtl/sysid_regs_axil_chk.sv
module sysid_regs_axil_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              arvalid,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              awvalid,
  input logic              wvalid,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp
);
  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    arvalid && arready |=> !rvalid ##1 !rvalid ##1 rvalid);
  // R10
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R11
  wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (awready || wready) |-> (awready && wready && awvalid && wvalid));
  // R11
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R11
  b_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    awready && awvalid && wvalid |=> bvalid && !awready);
  // R11
  resp_okay_chk: assert property (@(posedge clk) disable iff (rst)
    (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));
endmodule

bind sysid_regs_axil sysid_regs_axil_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .arvalid(axil_arvalid), .arready(axil_arready),
  .rvalid(axil_rvalid), .rready(axil_rready),
  .rdata(axil_rdata), .rresp(axil_rresp),
  .awvalid(axil_awvalid), .wvalid(axil_wvalid),
  .awready(axil_awready), .wready(axil_wready),
  .bvalid(axil_bvalid), .bready(axil_bready), .bresp(axil_bresp)
);

// File: tb/test_sysid_regs_axil.sv
module test_sysid_regs_axil;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_VAL     = 32'h1D00_BEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] awaddr = '0, araddr = '0;
  logic [2:0]  awprot = '0, arprot = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
  logic        arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, sys_q = '0, prr_q = '0;
  logic [8:0]  rom_word_addr;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [31:0] scr_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysid_regs_axil #(.ID_VALUE(ID_VAL)) i_sysid_regs_axil (
    .clk(clk), .rst(rst),
    .axil_awaddr(awaddr), .axil_awprot(awprot), .axil_awvalid(awvalid),
    .axil_awready(awready), .axil_wdata(wdata), .axil_wstrb(wstrb),
    .axil_wvalid(wvalid), .axil_wready(wready), .axil_bresp(bresp),
    .axil_bvalid(bvalid), .axil_bready(bready), .axil_araddr(araddr),
    .axil_arprot(arprot), .axil_arvalid(arvalid), .axil_arready(arready),
    .axil_rdata(rdata), .axil_rresp(rresp), .axil_rvalid(rvalid),
    .axil_rready(rready), .sys_rom_q(sys_q), .prr_rom_q(prr_q),
    .rom_word_addr(rom_word_addr)
  );

  function automatic logic [31:0] sys_fn(logic [8:0] a);
    return 32'hC0DE_0000 | {23'd0, a};
  endfunction

  function automatic logic [31:0] prr_fn(logic [8:0] a);
    return 32'hB0B0_0000 | {19'd0, ~a, 4'h5};
  endfunction

  // synchronous ROM models, one clock of latency
  always @(posedge clk) begin
    sys_q <= sys_fn(rom_word_addr);
    prr_q <= prr_fn(rom_word_addr);
  end

  function automatic logic [31:0] exp_read(logic [15:0] a);
    logic [13:0] w = a[15:2];
    if (w[13:9] == 5'd1) return sys_fn(w[8:0]);
    if (w[13:9] == 5'd2) return prr_fn(w[8:0]);
    case (w)
      14'd0:   return 32'h0001_0061;
      14'd1:   return ID_VAL;
      14'd2:   return scr_model;
      14'd3:   return 32'h5359_4944;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [15:0] a);
    logic [13:0] w = a[15:2];
    if (w[13:9] == 5'd1) return "R6";
    if (w[13:9] == 5'd2) return "R7";
    case (w)
      14'd0:   return "R2";
      14'd1:   return "R3";
      14'd2:   return "R4";
      14'd3:   return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a);
    logic [31:0] e;
    int d;
    string rq;
    e  = exp_read(a);
    rq = req_of(a);
    @(negedge clk);
    arvalid = 1'b1; araddr = a; arprot = 3'($urandom);
    chk("R10 arready idle", {31'd0, arready}, 32'd1);
    @(negedge clk);
    arvalid = 1'b0;
    chk("R10 rvalid+0", {31'd0, rvalid}, 32'd0);
    chk("R10 arready busy", {31'd0, arready}, 32'd0);
    if (rq == "R6" || rq == "R7")
      chk({rq, " rom_word_addr"}, {23'd0, rom_word_addr}, {23'd0, a[10:2]});
    @(negedge clk);
    chk("R10 rvalid+1", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    chk("R10 rvalid+2", {31'd0, rvalid}, 32'd1);
    chk(rq, rdata, e);
    chk("R11 rresp", {30'd0, rresp}, 32'd0);
    d = int'($urandom % 4);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R10 hold", {rvalid, rdata[30:0]}, {1'b1, e[30:0]});
    end
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk("R10 rvalid clear", {30'd0, rvalid, arready}, 32'd1);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] s, input int lead);
    int dl;
    @(negedge clk);
    awvalid = 1'b1; awaddr = a; awprot = 3'($urandom);
    for (int i = 0; i < lead; i++) begin
      @(negedge clk);
      chk("R11 aw alone", {30'd0, awready, wready}, 32'd0);
    end
    wvalid = 1'b1; wdata = d; wstrb = s;
    chk("R11 ready not yet", {30'd0, awready, wready}, 32'd0);
    @(negedge clk);
    chk("R11 ready pair", {30'd0, awready, wready}, 32'd3);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    chk("R11 bvalid", {29'd0, bvalid, awready, wready}, 32'd4);
    chk("R11 bresp", {30'd0, bresp}, 32'd0);
    if (a[15:2] == 14'd2)
      for (int b = 0; b < 4; b++) if (s[b]) scr_model[b*8 +: 8] = d[b*8 +: 8];
    dl = int'($urandom % 3);
    for (int i = 0; i < dl; i++) begin
      @(negedge clk);
      chk("R11 b hold", {31'd0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk("R11 bvalid clear", {31'd0, bvalid}, 32'd0);
  endtask

  function automatic logic [15:0] rand_addr();
    logic [13:0] w;
    case ($urandom % 6)
      0: w = 14'($urandom % 4);
      1: w = 14'h200 + 14'($urandom % 512);
      2: w = 14'h400 + 14'($urandom % 512);
      3: w = 14'd4 + 14'($urandom % 508);
      4: w = 14'h600 + 14'($urandom % 14'h3A00);
      default: w = 14'd2;
    endcase
    return {w, 2'b00};
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs", {28'd0, rvalid, bvalid, awready, wready}, 32'd0);
    chk("R1 arready", {31'd0, arready}, 32'd1);
    do_read(16'h0008);
    // R2 R3 R5 directed
    do_read(16'h0000);
    do_read(16'h0004);
    do_read(16'h000C);
    // R4 byte lanes
    do_write(16'h0008, 32'h1122_3344, 4'hF, 0);
    do_read(16'h0008);
    do_write(16'h0008, 32'hAABB_CCDD, 4'b0101, 2);
    do_read(16'h0008);
    do_write(16'h0008, 32'hEEFF_0011, 4'b0000, 0);
    do_read(16'h0008);
    // R6 R7 window edges
    do_read(16'h0800);
    do_read(16'h0FFC);
    do_read(16'h1000);
    do_read(16'h17FC);
    // R8 unmapped edges
    do_read(16'h0010);
    do_read(16'h07FC);
    do_read(16'h1800);
    do_read(16'hFFFC);
    // R9 writes to read-only places
    do_write(16'h0000, 32'hFFFF_FFFF, 4'hF, 1);
    do_write(16'h000C, 32'h0, 4'hF, 0);
    do_write(16'h0900, 32'h1234_5678, 4'hF, 0);
    do_write(16'h1004, 32'h1234_5678, 4'hF, 0);
    do_read(16'h0000);
    do_read(16'h000C);
    do_read(16'h0900);
    do_read(16'h1004);
    do_read(16'h0008);
    // mixed random traffic
    for (int n = 0; n < 200; n++) begin
      if ($urandom % 3 == 0)
        do_write(rand_addr(), $urandom, 4'($urandom), int'($urandom % 3));
      else
        do_read(rand_addr());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule